// File: doc/BRIEF.md
# Data-Dependent Sequential Multiplier

This block multiplies two word-sized operands one bit position at a time and returns the full double-width product. The caller places a multiplicand and a multiplier on the operand inputs, chooses unsigned or two's-complement interpretation with a mode input, and pulses a start input. The block then runs for a number of clocks that depends only on the multiplier operand and the mode. A single-cycle completion pulse marks the result, and a cycle count reports how long the operation took.

Each run has a fixed base length. Every bit position that calls for an addition or a subtraction adds two more clocks. In unsigned mode the multiplicand is added for each set multiplier bit. In signed mode the multiplier is recoded radix-2 Booth style. Each bit is paired with the bit below it, and a zero is assumed below the least significant bit. A pair whose current bit is 1 over a 0 below subtracts the shifted multiplicand. A pair whose current bit is 0 over a 1 below adds it. Equal pairs only shift. Start requests that arrive while an operation is in progress are dropped.

Top module: `dd_seq_mult`

## Requirements
- R1: A start pulse seen while idle makes busy rise on the next cycle. Busy stays high through the whole operation and is low in the cycle that done is high.
- R2: Done is a one-cycle pulse. It appears exactly 38 + 2N clock edges after the edge that accepted start, counting that edge as zero.
- R3: In unsigned mode, N is the number of 1 bits in the 16-bit multiplier.
- R4: In signed mode, N is the number of positions i from 0 to 15 where bit i differs from bit i-1, with bit -1 taken as 0.
- R5: In unsigned mode, the 32-bit product equals the multiplicand times the multiplier, both treated as unsigned.
- R6: In signed mode, the 32-bit product equals the two's-complement product of the two operands.
- R7: A start pulse during busy is ignored. The running operation's product and latency are unchanged, and no further operation follows it.
- R8: The cycle count output equals the number of busy cycles of the last completed operation, which is 38 + 2N. It is valid with done.
- R9: Product and cycle count change only when done rises. They hold their values at all other times, including while a following operation runs.
- R10: After reset, busy, done, product and cycle count are all zero.
- R11: A start given in the same cycle that done is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| mcand_i | input | 16 | Multiplicand operand |
| mplier_i | input | 16 | Multiplier operand; sets the latency |
| signed_i | input | 1 | 1 for two's-complement operands, 0 for unsigned |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_o | output | 32 | Product of the last completed operation |
| cycles_o | output | 7 | Busy-cycle count of the last completed operation |

## Verification
Completion and a fresh request can share one cycle. A start is driven in the very cycle that done is high. The bench then checks that the new operation's latency and product are exact, and that the earlier product stays on the output until the new done. A start can also coincide with the final busy cycle, where it must be dropped. The bench injects a start both there and in mid-run. It checks that the running result and latency are untouched and that busy stays low afterwards.

// File: rtl/ddm_pkg.sv
package ddm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,
      ST_EXAM,
      ST_ADD1,
      ST_ADD2,
      ST_FIN
   } seq_state_t;

   typedef struct packed {
      logic en;
      logic sub;
   } step_op_t;

endpackage

// File: rtl/ddm_recoder.sv
module ddm_recoder
   import ddm_pkg::*;
(
   input  logic     cur_bit_i,
   input  logic     prev_bit_i,
   input  logic     sgn_i,
   output step_op_t op_o
);

   always_comb begin
      if (sgn_i) begin
         op_o.en  = cur_bit_i ^ prev_bit_i;
         op_o.sub = cur_bit_i & ~prev_bit_i;
      end else begin
         op_o.en  = cur_bit_i;
         op_o.sub = 1'b0;
      end
   end

endmodule

// File: rtl/ddm_sequencer.sv
module ddm_sequencer
   import ddm_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int BASE_CYCLES = 38,
   parameter int CW          = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  step_op_t      op_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          load_o,
   output logic          stage_o,
   output logic          step_o,
   output logic          commit_o,
   output logic          finish_o,
   output logic [CW-1:0] cycles_o
);

   localparam int PREP_LEN = BASE_CYCLES - WIDTH - 1;
   localparam int PW       = (PREP_LEN > 1) ? $clog2(PREP_LEN) : 1;
   localparam int IW       = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam logic [PW-1:0] PREP_LAST = PW'(PREP_LEN - 1);
   localparam logic [IW-1:0] IDX_LAST  = IW'(WIDTH - 1);
   localparam logic [CW-1:0] BASE_C    = CW'(BASE_CYCLES);
   localparam logic [CW-1:0] MAX_C     = CW'(BASE_CYCLES + 2 * WIDTH);
   localparam logic          BASE_LSB  = BASE_C[0];

   seq_state_t    state_q;
   logic [PW-1:0] prep_q;
   logic [IW-1:0] idx_q;
   logic [CW-1:0] run_q;
   logic [CW-1:0] cycles_q;
   logic          done_q;

   assign busy_o   = (state_q != ST_IDLE);
   assign load_o   = (state_q == ST_IDLE) && start_i;
   assign stage_o  = (state_q == ST_ADD1);
   assign commit_o = (state_q == ST_ADD2);
   assign step_o   = commit_o || ((state_q == ST_EXAM) && !op_i.en);
   assign finish_o = (state_q == ST_FIN);
   assign done_o   = done_q;
   assign cycles_o = cycles_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         prep_q   <= '0;
         idx_q    <= '0;
         run_q    <= '0;
         cycles_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load_o) begin
            run_q <= CW'(1);
         end else if (busy_o) begin
            run_q <= run_q + CW'(1);
         end
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_PREP;
                  prep_q  <= PREP_LAST;
               end
            end
            ST_PREP: begin
               if (prep_q == '0) begin
                  state_q <= ST_EXAM;
                  idx_q   <= '0;
               end else begin
                  prep_q <= prep_q - PW'(1);
               end
            end
            ST_EXAM: begin
               if (op_i.en) begin
                  state_q <= ST_ADD1;
               end else if (idx_q == IDX_LAST) begin
                  state_q <= ST_FIN;
               end else begin
                  idx_q <= idx_q + IW'(1);
               end
            end
            ST_ADD1: begin
               state_q <= ST_ADD2;
            end
            ST_ADD2: begin
               if (idx_q == IDX_LAST) begin
                  state_q <= ST_FIN;
               end else begin
                  state_q <= ST_EXAM;
                  idx_q   <= idx_q + IW'(1);
               end
            end
            ST_FIN: begin
               state_q  <= ST_IDLE;
               done_q   <= 1'b1;
               cycles_q <= run_q;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2: an arithmetic step always occupies two consecutive cycles
   p_add_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADD1) |=> (state_q == ST_ADD2));

   // R2: completion is a single-cycle pulse
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: reported count lies within base .. base+2*WIDTH and has base parity
   p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((cycles_o >= BASE_C) && (cycles_o <= MAX_C) && (cycles_o[0] == BASE_LSB)));

   // R1: busy only rises after an accepted start
   p_busy_from_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

endmodule

// File: rtl/ddm_datapath.sv
module ddm_datapath
   import ddm_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               busy_i,
   input  logic               load_i,
   input  logic               stage_i,
   input  logic               step_i,
   input  logic               commit_i,
   input  logic               finish_i,
   input  step_op_t           op_i,
   input  logic [WIDTH-1:0]   mcand_i,
   input  logic [WIDTH-1:0]   mplier_i,
   input  logic               signed_i,
   output logic               cur_bit_o,
   output logic               prev_bit_o,
   output logic               sgn_o,
   output logic [2*WIDTH-1:0] prod_o
);

   localparam int DW = 2 * WIDTH;
   localparam logic [DW-1:0] ONE_D = DW'(1);

   logic [DW-1:0]    mcand_ext;
   logic [DW-1:0]    mcand_q;
   logic [DW-1:0]    addend_q;
   logic [DW-1:0]    acc_q;
   logic [DW-1:0]    prod_q;
   logic [WIDTH-1:0] mplier_q;
   logic             prev_q;
   logic             sgn_q;

   assign mcand_ext[WIDTH-1:0] = mcand_i;
   for (genvar g = WIDTH; g < DW; g++) begin : g_ext
      assign mcand_ext[g] = signed_i & mcand_i[WIDTH-1];
   end

   assign cur_bit_o  = mplier_q[0];
   assign prev_bit_o = prev_q;
   assign sgn_o      = sgn_q;
   assign prod_o     = prod_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         addend_q <= '0;
         acc_q    <= '0;
         prod_q   <= '0;
         mplier_q <= '0;
         prev_q   <= 1'b0;
         sgn_q    <= 1'b0;
      end else begin
         if (load_i) begin
            mcand_q  <= mcand_ext;
            mplier_q <= mplier_i;
            prev_q   <= 1'b0;
            acc_q    <= '0;
            sgn_q    <= signed_i;
         end else begin
            if (stage_i) begin
               addend_q <= op_i.sub ? (~mcand_q + ONE_D) : mcand_q;
            end
            if (step_i) begin
               mcand_q  <= {mcand_q[DW-2:0], 1'b0};
               prev_q   <= mplier_q[0];
               mplier_q <= {1'b0, mplier_q[WIDTH-1:1]};
               if (commit_i) begin
                  acc_q <= acc_q + addend_q;
               end
            end
         end
         if (finish_i) begin
            prod_q <= acc_q;
         end
      end
   end

   // R7: operating mode is frozen for the whole run
   p_mode_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !load_i) |=> $stable(sgn_q));

   // R9: visible product only moves at the completion edge
   p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !finish_i |=> $stable(prod_q));

endmodule

// File: rtl/dd_seq_mult.sv
module dd_seq_mult
   import ddm_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int BASE_CYCLES = 38,
   parameter int CW          = $clog2(BASE_CYCLES + 2 * WIDTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [WIDTH-1:0]   mcand_i,
   input  logic [WIDTH-1:0]   mplier_i,
   input  logic               signed_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [2*WIDTH-1:0] prod_o,
   output logic [CW-1:0]      cycles_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("dd_seq_mult: WIDTH must be at least 2");
   end
   if (BASE_CYCLES < WIDTH + 2) begin : g_bad_base
      $error("dd_seq_mult: BASE_CYCLES must be at least WIDTH + 2");
   end
   if ((1 << CW) <= BASE_CYCLES + 2 * WIDTH) begin : g_bad_cw
      $error("dd_seq_mult: CW too narrow for the longest run");
   end

   step_op_t op;
   logic     cur_bit, prev_bit, sgn;
   logic     load, stage, step, commit, finish;

   ddm_recoder u_rec (
      .cur_bit_i  (cur_bit),
      .prev_bit_i (prev_bit),
      .sgn_i      (sgn),
      .op_o       (op)
   );

   ddm_sequencer #(
      .WIDTH       (WIDTH),
      .BASE_CYCLES (BASE_CYCLES),
      .CW          (CW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .op_i     (op),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .load_o   (load),
      .stage_o  (stage),
      .step_o   (step),
      .commit_o (commit),
      .finish_o (finish),
      .cycles_o (cycles_o)
   );

   ddm_datapath #(
      .WIDTH (WIDTH)
   ) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (busy_o),
      .load_i     (load),
      .stage_i    (stage),
      .step_i     (step),
      .commit_i   (commit),
      .finish_i   (finish),
      .op_i       (op),
      .mcand_i    (mcand_i),
      .mplier_i   (mplier_i),
      .signed_i   (signed_i),
      .cur_bit_o  (cur_bit),
      .prev_bit_o (prev_bit),
      .sgn_o      (sgn),
      .prod_o     (prod_o)
   );

   // R1: completion coincides with the end of busy
   p_done_ends_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R4: subtraction steps only arise from signed recoding
   p_sub_signed_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && op.sub) |-> (sgn && op.en));

endmodule

// File: tb/dd_seq_mult_tb_top.sv
`timescale 1ns/1ps
module dd_seq_mult_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic [15:0] mcand_i;
   logic [15:0] mplier_i;
   logic        signed_i;
   logic        busy_o;
   logic        done_o;
   logic [31:0] prod_o;
   logic [6:0]  cycles_o;

   int n_chk  = 0;
   int n_fail = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   dd_seq_mult dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .mcand_i  (mcand_i),
      .mplier_i (mplier_i),
      .signed_i (signed_i),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .prod_o   (prod_o),
      .cycles_o (cycles_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int exp_n(input logic [15:0] b, input logic s);
      int n = 0;
      for (int i = 0; i < 16; i++) begin
         if (s) begin
            if (b[i] != ((i == 0) ? 1'b0 : b[i-1])) n++;
         end else if (b[i]) begin
            n++;
         end
      end
      return n;
   endfunction

   function automatic logic [31:0] exp_p(input logic [15:0] a, input logic [15:0] b, input logic s);
      logic signed [31:0] sa, sb;
      if (s) begin
         sa = {{16{a[15]}}, a};
         sb = {{16{b[15]}}, b};
         return sa * sb;
      end
      return {16'b0, a} * {16'b0, b};
   endfunction

   // Called at a negedge; returns at the negedge where done is high.
   // inject_at >= 0 drives a stray start in that busy cycle.
   task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic s,
                         input int inject_at);
      int          n = 0;
      int          lat;
      logic [31:0] prev_prod;
      logic        busy_ok = 1'b1;
      lat       = 38 + 2 * exp_n(b, s);
      prev_prod = prod_o;
      mcand_i   = a;
      mplier_i  = b;
      signed_i  = s;
      start_i   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chk("R1 busy rises after start", {31'b0, busy_o}, 32'd1);
      chk("R9 product held during next run", prod_o, prev_prod);
      while (!done_o && n < 200) begin
         if (!busy_o) busy_ok = 1'b0;
         if (n == inject_at) begin
            start_i  = 1'b1;
            mcand_i  = ~a;
            mplier_i = b ^ 16'h5A5A;
            signed_i = ~s;
         end else begin
            start_i = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
         n++;
      end
      start_i = 1'b0;
      chk("R1 busy held until done", {31'b0, busy_ok}, 32'd1);
      chk("R1 busy low with done", {31'b0, busy_o}, 32'd0);
      if (s) chk("R4 signed latency", n, lat);
      else   chk("R3 unsigned latency", n, lat);
      chk("R2 done at 38+2N", {31'b0, done_o}, 32'd1);
      if (s) chk("R6 signed product", prod_o, exp_p(a, b, s));
      else   chk("R5 unsigned product", prod_o, exp_p(a, b, s));
      chk("R8 cycle count", {25'b0, cycles_o}, lat);
   endtask

   task automatic idle_gap(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         if (i == 0) chk("R2 done lasts one cycle", {31'b0, done_o}, 32'd0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] vals [12];
      logic [31:0] held;
      vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'h8001,
               16'hFFFF, 16'h5555, 16'hAAAA, 16'h00FF, 16'hFF00, 16'h1234};
      rst_n    = 1'b0;
      start_i  = 1'b0;
      mcand_i  = '0;
      mplier_i = '0;
      signed_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 busy reset", {31'b0, busy_o}, 32'd0);
      chk("R10 done reset", {31'b0, done_o}, 32'd0);
      chk("R10 product reset", prod_o, 32'd0);
      chk("R10 count reset", {25'b0, cycles_o}, 32'd0);
      rst_n = 1'b1;
      idle_gap(2);

      // latency patterns: zero, all ones, alternating, single bits
      for (int s = 0; s < 2; s++) begin
         run_op(16'h1234, 16'h0000, s[0], -1); idle_gap(2);
         run_op(16'h1234, 16'hFFFF, s[0], -1); idle_gap(2);
         run_op(16'h1234, 16'h5555, s[0], -1); idle_gap(2);
         run_op(16'h1234, 16'hAAAA, s[0], -1); idle_gap(2);
         run_op(16'hFFFF, 16'h8000, s[0], -1); idle_gap(2);
         run_op(16'h8000, 16'h0001, s[0], -1); idle_gap(2);
      end

      // every one-count for R3
      for (int k = 0; k <= 16; k++) begin
         run_op(16'hBEEF, 16'((32'd1 << k) - 1), 1'b0, -1);
         idle_gap(1);
      end

      // corner operand sweep, both modes, back to back (R11)
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
               run_op(vals[i], vals[j], s[0], -1);
      idle_gap(2);

      // R11: start during done; previous product held then replaced
      run_op(16'h0003, 16'h0005, 1'b0, -1);
      held = prod_o;
      run_op(16'hFFFE, 16'h0007, 1'b1, -1);
      chk("R11 back-to-back result", prod_o, 32'hFFFFFFF2);
      chk("R9 earlier product was 15", held, 32'd15);
      idle_gap(2);

      // R7: stray starts mid-run and in the final busy cycle
      run_op(16'h4321, 16'h0F0F, 1'b0, 5);
      idle_gap(3);
      chk("R7 no follow-on run", {31'b0, busy_o}, 32'd0);
      run_op(16'h8765, 16'hF00F, 1'b1, 38 + 2 * exp_n(16'hF00F, 1'b1) - 1);
      idle_gap(3);
      chk("R7 final-cycle start dropped", {31'b0, busy_o}, 32'd0);
      chk("R9 product stable while idle", prod_o, exp_p(16'h8765, 16'hF00F, 1'b1));

      // pseudo-random operands
      for (int r = 0; r < 500; r++) begin
         logic [15:0] ra, rb;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ra   = lfsr;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rb   = lfsr ^ {lfsr[7:0], lfsr[15:8]};
         run_op(ra, rb, ra[3], -1);
         if (r % 7 == 0) idle_gap(1);
      end
      idle_gap(2);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule